// File: doc/BRIEF.md
# Glitchless Clock Source Selector

This block picks one of several free-running input clocks and passes it to a single output clock. The output never shows a shortened high or low pulse, even when the selection changes at an arbitrary moment. When the select field moves to a new index, the path that is driving the output is shut off first, inside its own clock domain. The new path is engaged only after the old one has been seen off. While neither path is engaged, the output stays low.

A one-hot status word shows which input is really driving the output at any moment. Software writes the select field and then polls the status bit of the new index before it relies on the new clock. Index 0 is the primary clock. Index 1 is meant to carry the output of an upstream auxiliary multiplexer. Before software changes that upstream multiplexer, it returns this selector to index 0 and waits for status bit 0.

Top module: `glitchfree_clk_sel`

## Requirements
- R1: While reset (synchronous, active low, held for several cycles of every source) is asserted and after it is released with select 0, the status word reads 0b0001 (bit 0 set, all others clear) and the output clock shows the same rising edges as input 0.
- R2: At no time is more than one status bit set.
- R3: After the select field is changed to index k, status bit k (bit position equals the index) sets within a bounded number of cycles of the old and new clocks, and only after the old index's bit has cleared.
- R4: Once status bit k is set, the output clock has exactly the rising edges of input k.
- R5: No high or low pulse on the output clock is shorter than the shorter half period of the two clocks involved in a switch.
- R6: While the status word is all zeros, the output clock is held low; every switch between two different indices passes through such an interval.
- R7: While the select field is stable and the switch to it has completed, the status word does not change.
- R8: Writing the index that is already selected has no effect: the status word stays unchanged and the output keeps every rising edge of that input.
- R9: Switching from any index back to index 0 completes in the same way as any other switch, so that index 0 can be confirmed before the upstream multiplexer on index 1 is altered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Synchronous active-low reset, sampled in every source domain |
| clk_in | input | N_SRC | Free-running candidate clocks, bit i is source i |
| sel | input | SEL_W | Index of the requested source |
| clk_out | output | 1 | Switched output clock |
| status | output | N_SRC | One-hot report of the source driving clk_out |

## Verification
A broken enable or synchroniser in one path shows up at the ports within a few cycles of the slower of the two clocks in a switch. It appears as two status bits set together, a status bit that rises while the old one is still set, a pulse on clk_out that is narrower than either half period, or an edge on clk_out while the status word is zero. A path that never engages leaves the status word at zero, and the poll for completion times out. A path that engages but gates the wrong clock gives a rising-edge count on clk_out that differs from that of the selected input over a fixed window.

// File: rtl/clksel_pkg.sv
// Package: shared constants for the glitchless clock selector.
// Assumes: two synchroniser stages are enough for the target process.
package clksel_pkg;
    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/clksel_sync.sv
// Module: clksel_sync
// Brings a level signal into the domain of clk through a flop chain.
// Assumes: d is a slow level; a synchronous reset loads RST_VAL into every stage.
module clksel_sync #(
    parameter int unsigned STAGES  = clksel_pkg::SYNC_STAGES,
    parameter bit          RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clksel_path.sv
// Module: clksel_path
// One source path: raises its request only when it is selected and every
// other path is off. The request is synchronised into this path's clock and
// the enable is loaded on the falling edge, so the gate changes only while
// the source is low.
// Assumes: clk_src is free running; others_on comes from other domains.
module clksel_path #(
    parameter bit START_ON = 1'b0
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic sel_hit,
    input  logic others_on,
    output logic en
);
    logic req;
    logic req_sync;

    assign req = sel_hit & ~others_on;

    clksel_sync #(
        .STAGES  (clksel_pkg::SYNC_STAGES),
        .RST_VAL (START_ON)
    ) u_sync (
        .clk   (clk_src),
        .rst_n (rst_n),
        .d     (req),
        .q     (req_sync)
    );

    // Update the gate enable while the source clock is low.
    always_ff @(negedge clk_src) begin
        if (!rst_n) en <= START_ON;
        else        en <= req_sync;
    end
endmodule

// File: rtl/glitchfree_clk_sel.sv
// Module: glitchfree_clk_sel (top)
// Glitchless selector over N_SRC free-running clocks. Each path gates its own
// clock; the gated clocks are ORed. The enables form the status word.
// Assumes: every clk_in is free running during reset and operation; sel is
// held until the matching status bit is set; an index of N_SRC or more
// selects no source.
module glitchfree_clk_sel #(
    parameter int unsigned N_SRC = 4,
    localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             rst_n,
    input  logic [N_SRC-1:0] clk_in,
    input  logic [SEL_W-1:0] sel,
    output logic             clk_out,
    output logic [N_SRC-1:0] status
);
    logic [N_SRC-1:0] en;

    for (genvar i = 0; i < N_SRC; i++) begin : g_path
        logic             hit;
        logic             busy;
        logic [N_SRC-1:0] mask;

        // Mask out this path when looking at the others.
        assign mask = ~(N_SRC'(1) << i);
        assign hit  = (sel == SEL_W'(i));
        assign busy = |(en & mask);

        clksel_path #(
            .START_ON (i == 0)
        ) u_path (
            .clk_src   (clk_in[i]),
            .rst_n     (rst_n),
            .sel_hit   (hit),
            .others_on (busy),
            .en        (en[i])
        );
    end

    assign clk_out = |(clk_in & en);
    assign status  = en;
endmodule

// File: rtl/glitchfree_clk_sel_chk.sv
// Module: glitchfree_clk_sel_chk
// Property checker for the selector, sampled on the primary clock.
// Assumes: sel stays put until its status bit has set.
module glitchfree_clk_sel_chk #(
    parameter int unsigned N_SRC = 4,
    localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input logic             rst_n,
    input logic [N_SRC-1:0] clk_in,
    input logic [SEL_W-1:0] sel,
    input logic             clk_out,
    input logic [N_SRC-1:0] status
);
    AST_STATUS_ONEHOT0: assert property (@(posedge clk_in[0]) disable iff (!rst_n)
        $onehot0(status)); // R2

    AST_DARK_WHEN_IDLE: assert property (@(posedge clk_in[0]) disable iff (!rst_n)
        (status == '0) |-> !clk_out); // R6

    AST_HOLD_WHEN_SETTLED: assert property (@(posedge clk_in[0]) disable iff (!rst_n)
        (($past(status) == (N_SRC'(1) << $past(sel))) && $stable(sel)) |-> $stable(status)); // R7

    for (genvar k = 0; k < N_SRC; k++) begin : g_rise
        AST_RISE_ONLY_REQUESTED: assert property (@(posedge clk_in[0]) disable iff (!rst_n)
            $rose(status[k]) |-> (sel == SEL_W'(k))); // R3
    end
endmodule

bind glitchfree_clk_sel glitchfree_clk_sel_chk #(.N_SRC(N_SRC)) u_chk (
    .rst_n   (rst_n),
    .clk_in  (clk_in),
    .sel     (sel),
    .clk_out (clk_out),
    .status  (status)
);

// File: tb/tb_glitchfree_clk_sel.sv
`timescale 1ns/100ps
module tb_glitchfree_clk_sel;
    localparam int N = 4;

    logic         rst_n;
    logic [N-1:0] clk_src;
    logic [1:0]   sel;
    logic         clk_out;
    logic [N-1:0] status;

    int checks = 0;
    int errors = 0;

    glitchfree_clk_sel #(.N_SRC(N)) dut (
        .rst_n   (rst_n),
        .clk_in  (clk_src),
        .sel     (sel),
        .clk_out (clk_out),
        .status  (status)
    );

    // Source 0 is 100 MHz; the others are unrelated so that edges rarely coincide.
    initial clk_src = '0;
    always #5.0 clk_src[0] = ~clk_src[0];
    always #7.1 clk_src[1] = ~clk_src[1];
    always #11.3 clk_src[2] = ~clk_src[2];
    always #3.3 clk_src[3] = ~clk_src[3];

    // Edge counters, one per signal.
    int e_out = 0, e0 = 0, e1 = 0, e2 = 0, e3 = 0;
    always @(posedge clk_out)    e_out++;
    always @(posedge clk_src[0]) e0++;
    always @(posedge clk_src[1]) e1++;
    always @(posedge clk_src[2]) e2++;
    always @(posedge clk_src[3]) e3++;

    // Monitors for runts, overlap and output activity while idle.
    realtime last_edge = 0;
    int runts = 0, overlaps = 0, dark_hits = 0;
    always @(clk_out) begin
        if (rst_n && ($realtime - last_edge) < 3.0) runts++;
        last_edge = $realtime;
    end
    always @(status) if ($countones(status) > 1) overlaps++;
    always @(posedge clk_out) if (rst_n && status == '0) dark_hits++;

    function automatic int src_edges(input int k);
        case (k)
            0: return e0;
            1: return e1;
            2: return e2;
            default: return e3;
        endcase
    endfunction

    task automatic wait_neg(input int k);
        case (k)
            0: @(negedge clk_src[0]);
            1: @(negedge clk_src[1]);
            2: @(negedge clk_src[2]);
            default: @(negedge clk_src[3]);
        endcase
        #0.1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count rising edges of clk_out and source k over 20 source cycles.
    task automatic edges_match(input int k, input string req);
        int o0, s0;
        wait_neg(k);
        o0 = e_out; s0 = src_edges(k);
        repeat (20) wait_neg(k);
        check((e_out - o0) == (src_edges(k) - s0), req, e_out - o0, src_edges(k) - s0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        sel   = '0;
        #400;
        check(status == 4'b0001, "R1 status in reset", int'(status), 1);
        @(negedge clk_src[0]);
        rst_n = 1'b1;
        #50;
        check(status == 4'b0001, "R1 status after reset", int'(status), 1);
        edges_match(0, "R1 output follows source 0");
    endtask

    task automatic t_switch(input int k, input string req);
        int r0, ov0, d0;
        bit seen_zero = 0, done = 0, order_ok = 1;
        logic [N-1:0] prev;
        r0 = runts; ov0 = overlaps; d0 = dark_hits;
        prev = status;
        #1.7;
        sel = 2'(k);
        for (int i = 0; i < 4000 && !done; i++) begin
            #0.5;
            if (status == '0) seen_zero = 1;
            if (status[k] && (status & ~(N'(1) << k)) != '0) order_ok = 0;
            if (status == (N'(1) << k)) done = 1;
        end
        check(done, {req, " R3 switch completes"}, int'(status), 1 << k);
        check(order_ok, "R3 new bit only after old bit clears", 0, 1);
        if (prev != (N'(1) << k))
            check(seen_zero, "R6 idle gap between paths", 0, 1);
        check(overlaps == ov0, "R2 at most one status bit", overlaps - ov0, 0);
        check(runts == r0, "R5 no runt pulse on clk_out", runts - r0, 0);
        check(dark_hits == d0, "R6 clk_out low while status zero", dark_hits - d0, 0);
        edges_match(k, "R4 output follows selected source");
    endtask

    task automatic t_hold(input int k);
        logic [N-1:0] snap;
        bit stable = 1;
        snap = status;
        for (int i = 0; i < 400; i++) begin
            #0.5;
            if (status != snap) stable = 0;
        end
        check(stable && snap == (N'(1) << k), "R7 status stable with sel stable", int'(status), 1 << k);
    endtask

    task automatic t_rewrite(input int k);
        int r0, d0;
        bit stable = 1;
        r0 = runts; d0 = dark_hits;
        #1.3;
        sel = 2'(k);
        for (int i = 0; i < 200; i++) begin
            #0.5;
            if (status != (N'(1) << k)) stable = 0;
        end
        check(stable, "R8 rewrite keeps status", int'(status), 1 << k);
        check(runts == r0 && dark_hits == d0, "R8 rewrite no interruption", runts - r0, 0);
        edges_match(k, "R8 rewrite keeps every edge");
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_switch(1, "to aux path");
        t_hold(1);
        t_switch(0, "R9 back to primary");
        t_switch(3, "to fast source");
        t_rewrite(3);
        t_switch(2, "fast to slow");
        t_hold(2);
        t_switch(1, "slow to aux");
        t_switch(0, "R9 aux to primary before aux change");
        t_rewrite(0);
        t_switch(2, "primary to slow");
        t_switch(0, "R9 slow to primary");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule